// File: doc/BRIEF.md
# System Management Interrupt Event Controller

This block watches a set of hardware and software event sources and turns a qualifying event into a one-cycle system management interrupt pulse. It also latches a cause code that firmware reads back to find out why the interrupt was raised. The sources are sixteen interrupt request lines plus NMI, eight DMA request lines, a monitor of memory and I/O write cycles that looks for accesses to the display adapter address windows, two already-debounced external switch strobes, and a software trigger.

Firmware configures the block through a pair of byte-wide I/O ports. The index port at 22h selects a configuration register. The data port at 23h reads or writes the selected register. Most sources are qualified three times: by a per-line select bit and by two global enable bits in separate registers. Request lines are edge-detected. When several sources qualify in the same clock, a fixed priority keeps one of them and drops the others.

All interfaces here are plain control and status pins: there is no data stream, so there is no valid/ready handshake and no back-pressure. The pulse and the cause are registered outputs.

Top module: `smi_event_ctrl`

## Requirements
- R1: A write to port 22h stores the index, and a read of 22h returns it. A read of 23h returns the selected register. Implemented indices are 56h, 57h, 58h, 59h, 5Ah, 5Bh, 5Ch, 5Dh, 5Eh and 66h. Any other index reads 00h and ignores writes. Index 5Bh is the read-only cause register, so writes to it are ignored.
- R2: Index 5Ch bit n selects IRQn for n = 0, 1, 3..7, and 5Ch bit 2 selects NMI in place of IRQ2. Index 5Dh bit n selects IRQ(n+8). A selected line raises an SMI with cause 08h only while 57h bit 3 and 5Ah bit 5 are both 1.
- R3: Index 5Eh bit n selects DRQn. A selected DRQ raises an SMI with cause 09h only while 57h bit 7 and 5Ah bit 6 are both 1.
- R4: A rising IRQ1 always raises an input-access SMI with cause 0Ah. 66h bit 7 adds IRQ3, bit 6 adds IRQ4 and bit 5 adds IRQ12 to this watch.
- R5: A rising IRQ8 reports cause 0Dh instead of 08h when 57h bit 3, 59h bit 6, 5Ah bit 5 and 5Dh bit 0 are all 1.
- R6: A data-port write to index 56h with bits 7 and 6 both 1 raises one SMI with cause 0Fh. Other values raise nothing.
- R7: When 57h bit 1 and 5Ah bit 0 are both 1, a display-window SMI with cause 11h is raised by either of two accesses. One is a monitored memory write to an address from 0A0000h through 0B0000h inclusive, while 66h bit 0 is 1. The other is a monitored I/O write to 3B0h through 3BFh, while 66h bit 1 is 1.
- R8: A switch-1 strobe raises cause 0Ch when 58h bit 6 is 1. A switch-2 strobe raises cause 10h when 58h bit 7 is 1.
- R9: IRQ, NMI and DRQ lines trigger on a low-to-high transition only. Holding a line high or dropping it raises nothing more.
- R10: When sources qualify in the same cycle, exactly one SMI is raised, for the first in this order: real-time-clock alarm, IRQ, DRQ, input access, switch 1, switch 2, display window, software. The others are discarded.
- R11: After reset the SMI output is 0 and the cause reads 00h. The cause changes only together with an SMI pulse and holds its value until the next one.
- R12: A qualifying input sampled at a clock edge produces an SMI pulse exactly one cycle wide, beginning at that same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_wr | input | 1 | Configuration port write strobe |
| io_rd | input | 1 | Configuration port read strobe |
| io_addr | input | 16 | Configuration port address (22h index, 23h data) |
| io_wdata | input | 8 | Configuration write data |
| io_rdata | output | 8 | Configuration read data (combinational, 0 when not reading) |
| irq | input | 16 | Interrupt request lines 15..0 |
| nmi | input | 1 | Non-maskable interrupt line |
| drq | input | 8 | DMA request lines 7..0 |
| mon_mem_wr | input | 1 | Observed memory write cycle |
| mon_io_wr | input | 1 | Observed I/O write cycle |
| mon_addr | input | 24 | Address of the observed write cycle |
| sw1_evt | input | 1 | Conditioned switch-1 strobe |
| sw2_evt | input | 1 | Conditioned switch-2 strobe |
| smi_pulse | output | 1 | One-cycle system management interrupt |
| smi_cause | output | 8 | Cause code of the most recent interrupt |

## Verification
The hardest case to reach is several sources qualifying in the very same clock, because the priority order and the discarding of losers are only visible then. The stimulus first opens every gate. It then raises an IRQ, a DRQ and a software-trigger write on one falling edge. It pairs a DRQ edge with a switch strobe, and an IRQ8 alarm with IRQ15, each time expecting one pulse with the winner's code. A quiet window afterwards catches any second pulse. The display-window limits are probed one address inside and one outside each end.

// File: rtl/smi_pkg.sv
package smi_pkg;

  localparam int NSRC = 8;

  typedef enum logic [2:0] {
    SRC_RTC   = 3'd0,
    SRC_IRQ   = 3'd1,
    SRC_DRQ   = 3'd2,
    SRC_INACC = 3'd3,
    SRC_SW1   = 3'd4,
    SRC_SW2   = 3'd5,
    SRC_VGA   = 3'd6,
    SRC_SOFT  = 3'd7
  } smi_src_e;

  localparam logic [7:0] CODE_IRQ   = 8'h08;
  localparam logic [7:0] CODE_DRQ   = 8'h09;
  localparam logic [7:0] CODE_INACC = 8'h0A;
  localparam logic [7:0] CODE_SW1   = 8'h0C;
  localparam logic [7:0] CODE_RTC   = 8'h0D;
  localparam logic [7:0] CODE_SOFT  = 8'h0F;
  localparam logic [7:0] CODE_SW2   = 8'h10;
  localparam logic [7:0] CODE_VGA   = 8'h11;

  typedef struct packed {
    logic [7:0] soft_ctl;   // 56h
    logic [7:0] gate_a;     // 57h
    logic [7:0] sw_en;      // 58h
    logic [7:0] rtc_ctl;    // 59h
    logic [7:0] gate_b;     // 5Ah
    logic [7:0] irq_lo;     // 5Ch
    logic [7:0] irq_hi;     // 5Dh
    logic [7:0] drq_sel;    // 5Eh
    logic [7:0] mon_sel;    // 66h
  } smi_cfg_t;

  function automatic logic [7:0] code_of(input smi_src_e s);
    case (s)
      SRC_RTC:   return CODE_RTC;
      SRC_IRQ:   return CODE_IRQ;
      SRC_DRQ:   return CODE_DRQ;
      SRC_INACC: return CODE_INACC;
      SRC_SW1:   return CODE_SW1;
      SRC_SW2:   return CODE_SW2;
      SRC_VGA:   return CODE_VGA;
      default:   return CODE_SOFT;
    endcase
  endfunction

endpackage

// File: rtl/smi_edge_det.sv
module smi_edge_det #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] rise
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= din;
  end

  assign rise = din & ~prev_q;
endmodule

// File: rtl/smi_cfg_regs.sv
module smi_cfg_regs
  import smi_pkg::*;
#(
  parameter int              IO_AW      = 16,
  parameter logic [IO_AW-1:0] PORT_INDEX = 'h22,
  parameter logic [IO_AW-1:0] PORT_DATA  = 'h23
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             io_wr,
  input  logic             io_rd,
  input  logic [IO_AW-1:0] io_addr,
  input  logic [7:0]       io_wdata,
  input  logic [7:0]       cause,
  output logic [7:0]       io_rdata,
  output smi_cfg_t         cfg,
  output logic             soft_fire
);
  logic [7:0] index_q;
  smi_cfg_t   cfg_q;
  logic       data_wr;
  logic [7:0] sel_val;

  assign data_wr = io_wr && (io_addr == PORT_DATA);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      index_q <= '0;
      cfg_q   <= '0;
    end else begin
      if (io_wr && (io_addr == PORT_INDEX)) index_q <= io_wdata;
      if (data_wr) begin
        case (index_q)
          8'h56: cfg_q.soft_ctl <= io_wdata;
          8'h57: cfg_q.gate_a   <= io_wdata;
          8'h58: cfg_q.sw_en    <= io_wdata;
          8'h59: cfg_q.rtc_ctl  <= io_wdata;
          8'h5A: cfg_q.gate_b   <= io_wdata;
          8'h5C: cfg_q.irq_lo   <= io_wdata;
          8'h5D: cfg_q.irq_hi   <= io_wdata;
          8'h5E: cfg_q.drq_sel  <= io_wdata;
          8'h66: cfg_q.mon_sel  <= io_wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (index_q)
      8'h56:   sel_val = cfg_q.soft_ctl;
      8'h57:   sel_val = cfg_q.gate_a;
      8'h58:   sel_val = cfg_q.sw_en;
      8'h59:   sel_val = cfg_q.rtc_ctl;
      8'h5A:   sel_val = cfg_q.gate_b;
      8'h5B:   sel_val = cause;
      8'h5C:   sel_val = cfg_q.irq_lo;
      8'h5D:   sel_val = cfg_q.irq_hi;
      8'h5E:   sel_val = cfg_q.drq_sel;
      8'h66:   sel_val = cfg_q.mon_sel;
      default: sel_val = 8'h00;
    endcase
  end

  always_comb begin
    io_rdata = 8'h00;
    if (io_rd && (io_addr == PORT_INDEX)) io_rdata = index_q;
    else if (io_rd && (io_addr == PORT_DATA)) io_rdata = sel_val;
  end

  assign soft_fire = data_wr && (index_q == 8'h56) && (io_wdata[7:6] == 2'b11);
  assign cfg       = cfg_q;
endmodule

// File: rtl/smi_window_match.sv
module smi_window_match #(
  parameter int               MON_AW  = 24,
  parameter logic [MON_AW-1:0] MEM_LO  = 'h0A0000,
  parameter logic [MON_AW-1:0] MEM_HI  = 'h0B0000,
  parameter logic [MON_AW-1:0] IO_LO   = 'h0003B0,
  parameter logic [MON_AW-1:0] IO_HI   = 'h0003BF
) (
  input  logic              mem_wr,
  input  logic              io_wr,
  input  logic [MON_AW-1:0] addr,
  input  logic              mem_en,
  input  logic              io_en,
  output logic              hit
);
  logic in_mem, in_io;
  assign in_mem = (addr >= MEM_LO) && (addr <= MEM_HI);
  assign in_io  = (addr >= IO_LO) && (addr <= IO_HI);
  assign hit    = (mem_wr && mem_en && in_mem) || (io_wr && io_en && in_io);
endmodule

// File: rtl/smi_prio_pick.sv
module smi_prio_pick
  import smi_pkg::*;
#(
  parameter int N = NSRC
) (
  input  logic [N-1:0]         req,
  output logic                 any,
  output logic [$clog2(N)-1:0] win
);
  logic [N-1:0][$clog2(N)-1:0] chain;

  // Lower index wins: walk from the top down, each stage overriding.
  generate
    for (genvar i = N - 1; i >= 0; i--) begin : g_stage
      if (i == N - 1) begin : g_top
        assign chain[i] = $clog2(N)'(i);
      end else begin : g_mid
        assign chain[i] = req[i] ? $clog2(N)'(i) : chain[i+1];
      end
    end
  endgenerate

  assign any = |req;
  assign win = chain[0];
endmodule

// File: rtl/smi_event_ctrl.sv
module smi_event_ctrl
  import smi_pkg::*;
#(
  parameter int IO_AW    = 16,
  parameter int MON_AW   = 24,
  parameter int IRQ_N    = 16,
  parameter int DRQ_N    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [IO_AW-1:0]  io_addr,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  input  logic [IRQ_N-1:0]  irq,
  input  logic              nmi,
  input  logic [DRQ_N-1:0]  drq,
  input  logic              mon_mem_wr,
  input  logic              mon_io_wr,
  input  logic [MON_AW-1:0] mon_addr,
  input  logic              sw1_evt,
  input  logic              sw2_evt,
  output logic              smi_pulse,
  output logic [7:0]        smi_cause
);
  localparam int SRCW = $clog2(NSRC);

  smi_cfg_t        cfg;
  logic            soft_fire;
  logic [IRQ_N:0]  line_rise;      // bit IRQ_N is NMI
  logic [DRQ_N-1:0] drq_rise;
  logic [IRQ_N-1:0] irq_slot;      // IRQ2 slot carries NMI
  logic [IRQ_N-1:0] irq_mask;
  logic            vga_hit;
  logic [NSRC-1:0] src_req;
  logic            any_req;
  logic [SRCW-1:0] win_idx;
  logic            pulse_q;
  logic [7:0]      cause_q;

  smi_cfg_regs #(.IO_AW(IO_AW)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .io_wr    (io_wr),
    .io_rd    (io_rd),
    .io_addr  (io_addr),
    .io_wdata (io_wdata),
    .cause    (cause_q),
    .io_rdata (io_rdata),
    .cfg      (cfg),
    .soft_fire(soft_fire)
  );

  smi_edge_det #(.W(IRQ_N + 1)) u_irq_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({nmi, irq}),
    .rise (line_rise)
  );

  smi_edge_det #(.W(DRQ_N)) u_drq_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (drq),
    .rise (drq_rise)
  );

  generate
    for (genvar i = 0; i < IRQ_N; i++) begin : g_slot
      if (i == 2) begin : g_nmi
        assign irq_slot[i] = line_rise[IRQ_N];
      end else begin : g_line
        assign irq_slot[i] = line_rise[i];
      end
    end
  endgenerate

  assign irq_mask = IRQ_N'({cfg.irq_hi, cfg.irq_lo});

  smi_window_match #(.MON_AW(MON_AW)) u_win (
    .mem_wr(mon_mem_wr),
    .io_wr (mon_io_wr),
    .addr  (mon_addr),
    .mem_en(cfg.mon_sel[0]),
    .io_en (cfg.mon_sel[1]),
    .hit   (vga_hit)
  );

  logic irq_gate, drq_gate, vga_gate;
  assign irq_gate = cfg.gate_a[3] & cfg.gate_b[5];
  assign drq_gate = cfg.gate_a[7] & cfg.gate_b[6];
  assign vga_gate = cfg.gate_a[1] & cfg.gate_b[0];

  always_comb begin
    src_req            = '0;
    src_req[SRC_RTC]   = line_rise[8] & cfg.irq_hi[0] & irq_gate & cfg.rtc_ctl[6];
    src_req[SRC_IRQ]   = |(irq_slot & irq_mask) & irq_gate;
    src_req[SRC_DRQ]   = |(drq_rise & cfg.drq_sel[DRQ_N-1:0]) & drq_gate;
    src_req[SRC_INACC] = line_rise[1]
                       | (line_rise[3]  & cfg.mon_sel[7])
                       | (line_rise[4]  & cfg.mon_sel[6])
                       | (line_rise[12] & cfg.mon_sel[5]);
    src_req[SRC_SW1]   = sw1_evt & cfg.sw_en[6];
    src_req[SRC_SW2]   = sw2_evt & cfg.sw_en[7];
    src_req[SRC_VGA]   = vga_hit & vga_gate;
    src_req[SRC_SOFT]  = soft_fire;
  end

  smi_prio_pick #(.N(NSRC)) u_pick (
    .req(src_req),
    .any(any_req),
    .win(win_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pulse_q <= 1'b0;
      cause_q <= 8'h00;
    end else begin
      pulse_q <= any_req;
      if (any_req) cause_q <= code_of(smi_src_e'(win_idx));
    end
  end

  assign smi_pulse = pulse_q;
  assign smi_cause = cause_q;
endmodule

// File: rtl/smi_event_ctrl_chk.sv
module smi_event_ctrl_chk #(
  parameter int IO_AW  = 16,
  parameter int MON_AW = 24,
  parameter int IRQ_N  = 16,
  parameter int DRQ_N  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              io_wr,
  input logic [IO_AW-1:0]  io_addr,
  input logic [IRQ_N-1:0]  irq,
  input logic              nmi,
  input logic [DRQ_N-1:0]  drq,
  input logic              mon_mem_wr,
  input logic              mon_io_wr,
  input logic              sw1_evt,
  input logic              sw2_evt,
  input logic              smi_pulse,
  input logic [7:0]        smi_cause
);
  logic started_q;
  always_ff @(posedge clk) begin
    if (!rst_n) started_q <= 1'b0;
    else        started_q <= 1'b1;
  end

  // R11: the cause moves only together with a pulse
  assert_cause_hold_R11: assert property (@(posedge clk) disable iff (!rst_n || !started_q)
    (smi_cause != $past(smi_cause)) |-> smi_pulse);

  // R2, R3, R4, R5, R6, R7, R8: only known codes appear on a pulse
  assert_known_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
    smi_pulse |-> (smi_cause inside {8'h08, 8'h09, 8'h0A, 8'h0C, 8'h0D, 8'h0F, 8'h10, 8'h11}));

  // R5: alarm code needs IRQ8 high in the sampling cycle
  assert_rtc_line_R5: assert property (@(posedge clk) disable iff (!rst_n || !started_q)
    (smi_pulse && smi_cause == 8'h0D) |-> $past(irq[8]));

  // R3: DRQ code needs some DRQ high in the sampling cycle
  assert_drq_line_R3: assert property (@(posedge clk) disable iff (!rst_n || !started_q)
    (smi_pulse && smi_cause == 8'h09) |-> $past(|drq));

  // R6: software code needs a data-port write
  assert_soft_write_R6: assert property (@(posedge clk) disable iff (!rst_n || !started_q)
    (smi_pulse && smi_cause == 8'h0F) |-> $past(io_wr && io_addr == IO_AW'('h23)));

  // R7: window code needs a monitored write
  assert_vga_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n || !started_q)
    (smi_pulse && smi_cause == 8'h11) |-> $past(mon_mem_wr || mon_io_wr));

  // R8: switch codes need their strobes
  assert_switch_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n || !started_q)
    (smi_pulse && (smi_cause == 8'h0C)) |-> $past(sw1_evt));

  // R12: no source active in the sampling cycle means no pulse
  assert_no_idle_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n || !started_q)
    $past(irq == '0 && !nmi && drq == '0 && !io_wr && !mon_mem_wr && !mon_io_wr
          && !sw1_evt && !sw2_evt) |-> !smi_pulse);
endmodule

bind smi_event_ctrl smi_event_ctrl_chk #(
  .IO_AW(IO_AW), .MON_AW(MON_AW), .IRQ_N(IRQ_N), .DRQ_N(DRQ_N)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .io_wr     (io_wr),
  .io_addr   (io_addr),
  .irq       (irq),
  .nmi       (nmi),
  .drq       (drq),
  .mon_mem_wr(mon_mem_wr),
  .mon_io_wr (mon_io_wr),
  .sw1_evt   (sw1_evt),
  .sw2_evt   (sw2_evt),
  .smi_pulse (smi_pulse),
  .smi_cause (smi_cause)
);

// File: tb/smi_event_ctrl_tb.sv
module smi_event_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        io_wr = 1'b0, io_rd = 1'b0;
  logic [15:0] io_addr = '0;
  logic [7:0]  io_wdata = '0;
  logic [7:0]  io_rdata;
  logic [15:0] irq = '0;
  logic        nmi = 1'b0;
  logic [7:0]  drq = '0;
  logic        mon_mem_wr = 1'b0, mon_io_wr = 1'b0;
  logic [23:0] mon_addr = '0;
  logic        sw1_evt = 1'b0, sw2_evt = 1'b0;
  logic        smi_pulse;
  logic [7:0]  smi_cause;

  int checks = 0, fails = 0, unexpected = 0, cyc = 0;
  int        exp_cyc[$];
  logic [7:0] exp_code[$];
  string     exp_tag[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  smi_event_ctrl u_dut (.*);

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && smi_pulse) begin
      if (exp_code.size() == 0) begin
        unexpected++;
        fails++; checks++;
        $display("FAIL R10 unexpected pulse at %0d cause=%02h expected none", cyc, smi_cause);
      end else begin
        automatic int   ec = exp_cyc.pop_front();
        automatic logic [7:0] ek = exp_code.pop_front();
        automatic string t = exp_tag.pop_front();
        checks++;
        if (ec != cyc || ek != smi_cause) begin
          fails++;
          $display("FAIL %s cycle=%0d cause=%02h expected cycle=%0d cause=%02h", t, cyc, smi_cause, ec, ek);
        end
      end
    end
  end

  task automatic expect_smi(input logic [7:0] code, input string tag);
    exp_cyc.push_back(cyc + 1);
    exp_code.push_back(code);
    exp_tag.push_back(tag);
  endtask

  task automatic quiet(input int n, input string tag);
    repeat (n) @(negedge clk);
    #1;
    checks++;
    if (exp_code.size() != 0) begin
      fails++;
      $display("FAIL %s missing pulse: %0d pending, expected 0", tag, exp_code.size());
      exp_cyc.delete(); exp_code.delete(); exp_tag.delete();
    end
  endtask

  task automatic io_put(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_wr = 1'b1; io_addr = a; io_wdata = d;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic set_reg(input logic [7:0] idx, input logic [7:0] d);
    io_put(16'h22, idx);
    io_put(16'h23, d);
  endtask

  task automatic check_reg(input logic [7:0] idx, input logic [7:0] expv, input string tag);
    io_put(16'h22, idx);
    @(negedge clk);
    io_rd = 1'b1; io_addr = 16'h23;
    #1;
    checks++;
    if (io_rdata !== expv) begin
      fails++;
      $display("FAIL %s reg %02h read=%02h expected=%02h", tag, idx, io_rdata, expv);
    end
    io_rd = 1'b0;
  endtask

  task automatic soft_write(input logic [7:0] d, input bit fires);
    io_put(16'h22, 8'h56);
    @(negedge clk);
    io_wr = 1'b1; io_addr = 16'h23; io_wdata = d;
    if (fires) expect_smi(8'h0F, "R6");
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic mon_write(input bit is_mem, input logic [23:0] a, input bit fires, input string tag);
    @(negedge clk);
    mon_mem_wr = is_mem; mon_io_wr = !is_mem; mon_addr = a;
    if (fires) expect_smi(8'h11, tag);
    @(negedge clk);
    mon_mem_wr = 1'b0; mon_io_wr = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    checks++;
    if (smi_pulse !== 1'b0 || smi_cause !== 8'h00) begin
      fails++;
      $display("FAIL R11 reset pulse=%b cause=%02h expected 0/00", smi_pulse, smi_cause);
    end
    check_reg(8'h5B, 8'h00, "R11");

    // R1: port access
    set_reg(8'h5C, 8'hA5);
    check_reg(8'h5C, 8'hA5, "R1");
    set_reg(8'h40, 8'h77);
    check_reg(8'h40, 8'h00, "R1");
    set_reg(8'h5B, 8'h55);
    check_reg(8'h5B, 8'h00, "R1");
    @(negedge clk); io_rd = 1'b1; io_addr = 16'h22; #1;
    checks++;
    if (io_rdata !== 8'h5B) begin fails++; $display("FAIL R1 index read=%02h expected=5B", io_rdata); end
    io_rd = 1'b0;

    // R2: gates closed => nothing
    @(negedge clk); irq[5] = 1'b1;
    quiet(4, "R2");
    irq[5] = 1'b0;
    set_reg(8'h57, 8'h8A);
    set_reg(8'h5A, 8'h61);
    set_reg(8'h5C, 8'h24);
    set_reg(8'h5D, 8'h80);
    @(negedge clk); irq[5] = 1'b1; expect_smi(8'h08, "R2");
    quiet(5, "R9");               // held high: one pulse only
    irq[5] = 1'b0;
    quiet(3, "R9");               // falling: nothing
    @(negedge clk); irq[2] = 1'b1;
    quiet(3, "R2");               // slot 2 belongs to NMI
    irq[2] = 1'b0;
    @(negedge clk); nmi = 1'b1; expect_smi(8'h08, "R2");
    quiet(3, "R2");
    nmi = 1'b0;
    @(negedge clk); irq[15] = 1'b1; expect_smi(8'h08, "R2");
    quiet(3, "R2");
    irq[15] = 1'b0;

    // R3: DRQ
    set_reg(8'h5E, 8'h10);
    @(negedge clk); drq[4] = 1'b1; expect_smi(8'h09, "R3");
    quiet(3, "R3");
    drq[4] = 1'b0;
    @(negedge clk); drq[3] = 1'b1;
    quiet(3, "R3");
    drq[3] = 1'b0;

    // R4: input access
    @(negedge clk); irq[1] = 1'b1; expect_smi(8'h0A, "R4");
    quiet(3, "R4");
    irq[1] = 1'b0;
    @(negedge clk); irq[4] = 1'b1;
    quiet(3, "R4");
    irq[4] = 1'b0;
    set_reg(8'h66, 8'h40);
    @(negedge clk); irq[4] = 1'b1; expect_smi(8'h0A, "R4");
    quiet(3, "R4");
    irq[4] = 1'b0;
    @(negedge clk); irq[3] = 1'b1;
    quiet(3, "R4");
    irq[3] = 1'b0;

    // R5: alarm
    set_reg(8'h5D, 8'h81);
    @(negedge clk); irq[8] = 1'b1; expect_smi(8'h08, "R5");
    quiet(3, "R5");
    irq[8] = 1'b0;
    set_reg(8'h59, 8'h40);
    @(negedge clk); irq[8] = 1'b1; expect_smi(8'h0D, "R5");
    quiet(3, "R5");
    irq[8] = 1'b0;

    // R8: switches
    set_reg(8'h58, 8'h40);
    @(negedge clk); sw1_evt = 1'b1; expect_smi(8'h0C, "R8");
    @(negedge clk); sw1_evt = 1'b0;
    quiet(2, "R8");
    @(negedge clk); sw2_evt = 1'b1;
    @(negedge clk); sw2_evt = 1'b0;
    quiet(2, "R8");
    set_reg(8'h58, 8'hC0);
    @(negedge clk); sw2_evt = 1'b1; expect_smi(8'h10, "R8");
    @(negedge clk); sw2_evt = 1'b0;
    quiet(2, "R8");

    // R7: display window
    set_reg(8'h66, 8'h41);
    mon_write(1'b1, 24'h0A0000, 1'b1, "R7");
    mon_write(1'b1, 24'h0B0000, 1'b1, "R7");
    mon_write(1'b1, 24'h0B0001, 1'b0, "R7");
    mon_write(1'b1, 24'h09FFFF, 1'b0, "R7");
    mon_write(1'b0, 24'h0003B0, 1'b0, "R7");  // io half disabled
    quiet(2, "R7");
    set_reg(8'h66, 8'h43);
    mon_write(1'b0, 24'h0003BF, 1'b1, "R7");
    mon_write(1'b0, 24'h0003C0, 1'b0, "R7");
    quiet(2, "R7");

    // R6: software
    soft_write(8'hC0, 1'b1);
    quiet(2, "R6");
    soft_write(8'h80, 1'b0);
    quiet(2, "R6");

    // R10: same-cycle contention
    io_put(16'h22, 8'h56);
    @(negedge clk);
    irq[5] = 1'b1; drq[4] = 1'b1;
    io_wr = 1'b1; io_addr = 16'h23; io_wdata = 8'hC0;
    expect_smi(8'h08, "R10");
    @(negedge clk); io_wr = 1'b0;
    quiet(3, "R10");
    irq[5] = 1'b0; drq[4] = 1'b0;
    @(negedge clk); drq[4] = 1'b1; sw1_evt = 1'b1; expect_smi(8'h09, "R10");
    @(negedge clk); sw1_evt = 1'b0;
    quiet(3, "R10");
    drq[4] = 1'b0;
    check_reg(8'h5B, 8'h09, "R11");
    @(negedge clk); irq[8] = 1'b1; irq[15] = 1'b1; expect_smi(8'h0D, "R10");
    quiet(3, "R10");
    irq[8] = 1'b0; irq[15] = 1'b0;
    check_reg(8'h5B, 8'h0D, "R11");
    quiet(4, "R12");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule